// File: doc/BRIEF.md
# Coherent Byte-Access Match Register

This block holds a 16-bit compare value for a serial port's receive path and makes it reachable from an 8-bit bus as two byte lanes, high and low. In wide mode the word is always read and written as a whole.

The first byte read in a pair takes a snapshot of the complete word. The partner byte is then served from that snapshot, so both halves come from one value even if the stored word changes in between. Byte writes are parked in a staging buffer. The stored word changes only on the write that completes a high/low pair, and it then takes both halves in one cycle. Either byte may come first in both directions.

With wide mode off, only the low byte matters. Low-byte writes land directly in the stored word, and no buffering takes place.

Top module: `coh_match_reg`

## Requirements
- R1: After reset the stored word is 0x0000, `match_value_o` reads 0x0000, `rdata_o` reads 0x00, and neither a read nor a write pair is pending.
- R2: In wide mode, a read with nothing pending returns the current stored byte for the selected lane (`sel_hi_i`=1 high, 0 low) on `rdata_o`, one cycle after the read strobe, and snapshots the whole word.
- R3: While a read snapshot is held, a read of the other lane returns that lane's snapshot byte, even if the stored word was changed after the snapshot, and then releases the snapshot.
- R4: While a read snapshot is held, a repeated read of the lane that was read first returns the snapshot byte and keeps the snapshot held.
- R5: In wide mode, the first write of a pair leaves the stored word and `match_value_o` unchanged.
- R6: In wide mode, a write to the lane other than the pending one commits both staged bytes at that clock edge. This holds in either order, and the new word shows on `match_value_o` right after that edge.
- R7: A second write to the lane already pending replaces its staged byte, does not commit, and keeps the pair open.
- R8: A read issued while a write pair is incomplete returns the stored word's byte, not the staged byte.
- R9: With wide mode off:
  - a low-lane write updates stored bits 7:0 at once;
  - high-lane writes are ignored;
  - high-lane reads return 0x00;
  - `match_value_o` shows zero above bit 7;
  - stored bits 15:8 are kept;
  - both pending flags are cleared, so a write pair opened before narrow mode does not complete after wide mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_mode_i | input | 1 | 1 selects coherent 16-bit access, 0 selects low-byte-only access |
| rd_en_i | input | 1 | Byte read strobe, one cycle per access |
| wr_en_i | input | 1 | Byte write strobe, one cycle per access |
| sel_hi_i | input | 1 | Lane select: 1 high byte, 0 low byte |
| wdata_i | input | BYTE_W | Write byte |
| rdata_o | output | BYTE_W | Read byte, registered, valid the cycle after the strobe |
| match_value_o | output | 2*BYTE_W | Compare value presented to the receive logic |

## Verification
The assertions take for granted that each strobe lasts a single cycle and that `sel_hi_i` and `wdata_i` are meaningful only while a strobe is high. They also assume a read and a write are not issued in the same cycle. The stimulus drives every access from one task that raises exactly one strobe for one cycle and drops it at the next falling edge. Mode changes are made only between accesses, so no strobe is in flight when `wide_mode_i` moves.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_e;
endpackage

// File: rtl/coh_wr_stage.sv
module coh_wr_stage
   import coh_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              wr_en_i,
   input  half_e             sel_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic              commit_o,
   output logic [WORD_W-1:0] commit_word_o,
   output logic              pend_o,
   output half_e             first_o
);
   logic [BYTE_W-1:0] stage_lo_q, stage_hi_q;
   logic              pend_q;
   half_e             first_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_lo_q <= '0;
         stage_hi_q <= '0;
         pend_q     <= 1'b0;
         first_q    <= HALF_LO;
      end else if (clr_i) begin
         pend_q     <= 1'b0;
      end else if (wr_en_i) begin
         if (sel_i == HALF_HI) stage_hi_q <= wdata_i;
         else                  stage_lo_q <= wdata_i;
         if (!pend_q) begin
            pend_q  <= 1'b1;
            first_q <= sel_i;
         end else if (sel_i != first_q) begin
            pend_q  <= 1'b0;
         end
      end
   end

   assign commit_o      = !clr_i && wr_en_i && pend_q && (sel_i != first_q);
   assign commit_word_o = (sel_i == HALF_HI) ? {wdata_i, stage_lo_q}
                                             : {stage_hi_q, wdata_i};
   assign pend_o        = pend_q;
   assign first_o       = first_q;
endmodule

// File: rtl/coh_rd_snap.sv
module coh_rd_snap
   import coh_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              rd_en_i,
   input  half_e             sel_i,
   input  logic [WORD_W-1:0] live_i,
   output logic [BYTE_W-1:0] rd_byte_o,
   output logic              pend_o,
   output half_e             first_o,
   output logic [WORD_W-1:0] snap_o
);
   logic [WORD_W-1:0] snap_q;
   logic              pend_q;
   half_e             first_q;
   logic [WORD_W-1:0] src;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         snap_q  <= '0;
         pend_q  <= 1'b0;
         first_q <= HALF_LO;
      end else if (clr_i) begin
         pend_q  <= 1'b0;
      end else if (rd_en_i) begin
         if (!pend_q) begin
            snap_q  <= live_i;
            pend_q  <= 1'b1;
            first_q <= sel_i;
         end else if (sel_i != first_q) begin
            pend_q  <= 1'b0;
         end
      end
   end

   always_comb begin
      src = pend_q ? snap_q : live_i;
      if (clr_i)
         rd_byte_o = (sel_i == HALF_HI) ? '0 : live_i[BYTE_W-1:0];
      else
         rd_byte_o = (sel_i == HALF_HI) ? src[WORD_W-1:BYTE_W]
                                        : src[BYTE_W-1:0];
   end

   assign pend_o  = pend_q;
   assign first_o = first_q;
   assign snap_o  = snap_q;
endmodule

// File: rtl/coh_match_reg.sv
module coh_match_reg
   import coh_pkg::*;
#(
   parameter int          BYTE_W    = 8,
   parameter bit          REG_RDATA = 1'b1,
   localparam int         WORD_W    = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wide_mode_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic              sel_hi_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic [WORD_W-1:0] match_value_o
);
   if (BYTE_W < 1) begin : g_bad_width
      $error("coh_match_reg: BYTE_W must be at least 1");
   end

   half_e             sel;
   logic              narrow;
   logic [WORD_W-1:0] live_q;
   logic              commit;
   logic [WORD_W-1:0] commit_word;
   logic              wr_pend, rd_pend;
   half_e             wr_first, rd_first;
   logic [WORD_W-1:0] snap;
   logic [BYTE_W-1:0] rd_byte;

   assign sel    = half_e'(sel_hi_i);
   assign narrow = !wide_mode_i;

   coh_wr_stage #(.BYTE_W(BYTE_W)) u_wr (
      .clk_i, .rst_ni, .clr_i(narrow), .wr_en_i,
      .sel_i(sel), .wdata_i,
      .commit_o(commit), .commit_word_o(commit_word),
      .pend_o(wr_pend), .first_o(wr_first)
   );

   coh_rd_snap #(.BYTE_W(BYTE_W)) u_rd (
      .clk_i, .rst_ni, .clr_i(narrow), .rd_en_i,
      .sel_i(sel), .live_i(live_q),
      .rd_byte_o(rd_byte), .pend_o(rd_pend),
      .first_o(rd_first), .snap_o(snap)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         live_q <= '0;
      else if (commit)
         live_q <= commit_word;
      else if (narrow && wr_en_i && sel == HALF_LO)
         live_q[BYTE_W-1:0] <= wdata_i;
   end

   assign match_value_o = wide_mode_i ? live_q
                                      : {{BYTE_W{1'b0}}, live_q[BYTE_W-1:0]};

   if (REG_RDATA) begin : g_rdata_reg
      logic [BYTE_W-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      rdata_q <= '0;
         else if (rd_en_i) rdata_q <= rd_byte;
      end
      assign rdata_o = rdata_q;
   end else begin : g_rdata_comb
      assign rdata_o = rd_en_i ? rd_byte : '0;
   end
endmodule

// File: rtl/coh_match_reg_chk.sv
module coh_match_reg_chk #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wide_mode_i,
   input logic              rd_en_i,
   input logic              wr_en_i,
   input logic              sel_hi_i,
   input logic [WORD_W-1:0] live,
   input logic              wr_pend,
   input logic              wr_first,
   input logic              rd_pend,
   input logic              rd_first,
   input logic [WORD_W-1:0] snap
);
   // R5: opening a write pair leaves the stored word alone
   a_r5_open_keeps_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_mode_i && wr_en_i && !wr_pend |=> $stable(live));

   // R6: the partner write closes the pair
   a_r6_partner_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_mode_i && wr_en_i && wr_pend && (sel_hi_i != wr_first) |=> !wr_pend);

   // R7: same-lane rewrite keeps the pair open and commits nothing
   a_r7_same_lane_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_mode_i && wr_en_i && wr_pend && (sel_hi_i == wr_first)
      |=> wr_pend && $stable(live));

   // R3: reading the partner lane releases the snapshot
   a_r3_partner_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_mode_i && rd_en_i && rd_pend && (sel_hi_i != rd_first) |=> !rd_pend);

   // R4: a held snapshot stays frozen
   a_r4_snap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_pend |=> $stable(snap));

   // R9: narrow mode leaves nothing pending
   a_r9_narrow_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wide_mode_i |=> !wr_pend && !rd_pend);
endmodule

bind coh_match_reg coh_match_reg_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wide_mode_i(wide_mode_i),
   .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .sel_hi_i(sel_hi_i),
   .live(live_q), .wr_pend(wr_pend), .wr_first(wr_first),
   .rd_pend(rd_pend), .rd_first(rd_first), .snap(snap)
);

// File: tb/coh_match_reg_bench.sv
module coh_match_reg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide = 1'b1;
   logic        rd_en = 1'b0, wr_en = 1'b0, sel_hi = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [15:0] match;
   int          n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   coh_match_reg u_coh_match_reg (
      .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide),
      .rd_en_i(rd_en), .wr_en_i(wr_en), .sel_hi_i(sel_hi),
      .wdata_i(wdata), .rdata_o(rdata), .match_value_o(match)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic hi, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; sel_hi = hi; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic hi, output logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; sel_hi = hi;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic t_reset;
      check("R1 match", match, 16'h0000);
      check("R1 rdata", {8'h00, rdata}, 16'h0000);
   endtask

   task automatic t_write_orders;
      wr(1'b0, 8'h34); check("R5 lo first", match, 16'h0000);
      wr(1'b1, 8'h12); check("R6 lo-hi", match, 16'h1234);
      wr(1'b1, 8'hAB); check("R5 hi first", match, 16'h1234);
      wr(1'b0, 8'hCD); check("R6 hi-lo", match, 16'hABCD);
   endtask

   task automatic t_same_lane;
      wr(1'b0, 8'h11); wr(1'b0, 8'h22);
      check("R7 no commit", match, 16'hABCD);
      wr(1'b1, 8'h33); check("R7 replaced", match, 16'h3322);
   endtask

   task automatic t_read_pending_write;
      logic [7:0] d;
      wr(1'b0, 8'h55);
      rd(1'b0, d); check("R8 lo live", {8'h00, d}, 16'h0022);
      rd(1'b1, d); check("R8 hi live", {8'h00, d}, 16'h0033);
      wr(1'b1, 8'h66); check("R6 after read", match, 16'h6655);
   endtask

   task automatic t_snapshot;
      logic [7:0] d;
      rd(1'b1, d); check("R2 hi", {8'h00, d}, 16'h0066);
      wr(1'b0, 8'h01); wr(1'b1, 8'h02);
      check("R6 during snap", match, 16'h0201);
      rd(1'b1, d); check("R4 repeat", {8'h00, d}, 16'h0066);
      rd(1'b0, d); check("R3 partner", {8'h00, d}, 16'h0055);
      rd(1'b0, d); check("R2 fresh", {8'h00, d}, 16'h0001);
      rd(1'b1, d); check("R3 fresh pair", {8'h00, d}, 16'h0002);
   endtask

   task automatic t_narrow;
      logic [7:0] d;
      @(negedge clk); wide = 1'b0;
      wr(1'b0, 8'h77); check("R9 lo direct", match, 16'h0077);
      wr(1'b1, 8'h99); check("R9 hi ignored", match, 16'h0077);
      rd(1'b1, d); check("R9 hi read", {8'h00, d}, 16'h0000);
      rd(1'b0, d); check("R9 lo read", {8'h00, d}, 16'h0077);
      @(negedge clk); wide = 1'b1;
      @(negedge clk); check("R9 hi kept", match, 16'h0277);
      wr(1'b1, 8'h44);
      @(negedge clk); wide = 1'b0;
      @(negedge clk); wide = 1'b1;
      wr(1'b0, 8'h88); check("R9 pair cleared", match, 16'h0277);
      wr(1'b1, 8'h10); check("R9 new pair", match, 16'h1088);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_write_orders();
            t_same_lane();
            t_read_pending_write();
            t_snapshot();
            t_narrow();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule